// File: doc/BRIEF.md
# Word-Addressed GPIO Register Block with Gated Set/Clear

This block is a small memory-mapped controller for up to 32 general-purpose pins. It keeps three 32-bit words: a pin level word that drives the pads, a direction word that drives the pad output enables (1 = output), and a spare word that software may use freely. A simple synchronous register bus reaches them: address, write strobe, read strobe and write data, with registered read data.

The level word is never written directly. Software raises bits through a set address and lowers them through a clear address. Either write takes effect only when its data has at least one bit in common with the direction word. When it does, the whole written word is applied, including bits that are currently inputs. A set or clear with no such overlap changes nothing and raises a one-cycle error strobe. The edge-control addresses are accepted and ignored. Any other address, including one not on a word boundary, raises the error strobe and reads back as zero.

Top module: `gpio_sc_top`

## Requirements
- R1: A read at 0x00 returns the level word, at 0x04 the direction word and at 0x20 the spare word. The value appears on `bus_rdata` on the clock edge that samples `bus_rd`, is visible from the next cycle, and reflects state from before any write in the same cycle. `bus_rdata` holds its value in cycles without a read.
- R2: A write at 0x04 loads all 32 bits of `bus_wdata` into the direction word, and `pad_oe` always equals the direction word (bit = 1 means output).
- R3: A write at 0x08 whose data ANDed with the direction word is nonzero ORs the full data word into the level word. `pad_out` always equals the level word.
- R4: A write at 0x0C whose data ANDed with the direction word is nonzero clears every level bit that is 1 in the data word.
- R5: A set or clear write whose data has no bit in common with the direction word leaves the level word unchanged and asserts `access_err` in that cycle.
- R6: Writes at 0x10, 0x14 and 0x18 raise no error and change none of the three words.
- R7: A write at 0x20 loads all 32 bits of `bus_wdata` into the spare word.
- R8: During and after reset, the level, direction and spare words are zero, and so are `pad_out`, `pad_oe` and `bus_rdata`.
- R9: A write to any address other than 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x20 changes nothing and asserts `access_err`. A read from any address other than 0x00, 0x04 or 0x20 returns zero and asserts `access_err`. Addresses that are not multiples of 4 are always in these groups.
- R10: `access_err` is combinational and is high only in a cycle with `bus_wr` or `bus_rd` asserted. A read and a write in the same cycle are judged independently, and the strobe is their OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_out | output | 32 | Pad output values (level word) |
| pad_oe | output | 32 | Pad output enables (direction word) |
| access_err | output | 1 | Error strobe for illegal accesses |

## Verification
The assertions check, on every cycle, the properties tied to a single access. A direction load shows up on the enables. An accepted set or clear leaves the written bits high or low. A gated-off set or clear and the edge-control writes leave state stable. A bad read returns zero. Read data holds between reads, and the error strobe never fires without an access. Only the bench's scenarios can show the rest. These are that a set applies even the input bits of its word, that a read and a write in the same cycle return the old value, and that every address in the 8-bit space falls into the right group. The bench covers the space with a full address sweep against an arithmetic model of the three words.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  localparam int unsigned WORD_W = 32;

  localparam int unsigned OFF_LEVEL = 'h00;
  localparam int unsigned OFF_DIR   = 'h04;
  localparam int unsigned OFF_SET   = 'h08;
  localparam int unsigned OFF_CLR   = 'h0C;
  localparam int unsigned OFF_RISE  = 'h10;
  localparam int unsigned OFF_FALL  = 'h14;
  localparam int unsigned OFF_EDGE  = 'h18;
  localparam int unsigned OFF_AUX   = 'h20;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    WOP_DIR,
    WOP_SET,
    WOP_CLR,
    WOP_EDGE,
    WOP_AUX,
    WOP_BAD
  } wr_op_t;

  typedef enum logic [1:0] {
    RK_LEVEL,
    RK_DIR,
    RK_AUX,
    RK_BAD
  } rd_kind_t;

  // A set/clear is allowed when the data touches at least one output bit.
  function automatic logic touches_output(input word_t data, input word_t dir);
    return |(data & dir);
  endfunction

  function automatic word_t apply_set(input word_t level, input word_t data);
    return level | data;
  endfunction

  function automatic word_t apply_clr(input word_t level, input word_t data);
    return level & ~data;
  endfunction

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output wr_op_t            wr_op,
  output rd_kind_t          rd_kind
);

  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFF_LEVEL);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(OFF_RISE);
  localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(OFF_FALL);
  localparam logic [ADDR_W-1:0] A_EDGE  = ADDR_W'(OFF_EDGE);
  localparam logic [ADDR_W-1:0] A_AUX   = ADDR_W'(OFF_AUX);

  always_comb begin
    wr_op = WOP_BAD;
    if (addr == A_DIR)       wr_op = WOP_DIR;
    else if (addr == A_SET)  wr_op = WOP_SET;
    else if (addr == A_CLR)  wr_op = WOP_CLR;
    else if (addr == A_RISE || addr == A_FALL || addr == A_EDGE)
                             wr_op = WOP_EDGE;
    else if (addr == A_AUX)  wr_op = WOP_AUX;
  end

  always_comb begin
    rd_kind = RK_BAD;
    if (addr == A_LEVEL)     rd_kind = RK_LEVEL;
    else if (addr == A_DIR)  rd_kind = RK_DIR;
    else if (addr == A_AUX)  rd_kind = RK_AUX;
  end

endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
  import gpio_sc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr,
  input  wr_op_t wr_op,
  input  word_t  wdata,
  output word_t  level,
  output word_t  dir,
  output word_t  aux,
  output logic   gate_miss
);

  logic is_setclr;
  logic gate_hit;

  assign is_setclr = wr && (wr_op == WOP_SET || wr_op == WOP_CLR);
  assign gate_hit  = touches_output(wdata, dir);
  assign gate_miss = is_setclr && !gate_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      dir   <= '0;
      aux   <= '0;
    end else if (wr) begin
      case (wr_op)
        WOP_DIR: dir <= wdata;
        WOP_SET: if (gate_hit) level <= apply_set(level, wdata);
        WOP_CLR: if (gate_hit) level <= apply_clr(level, wdata);
        WOP_AUX: aux <= wdata;
        default: ;
      endcase
    end
  end

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_op == WOP_DIR) |=> (dir == $past(wdata)));

  // R3
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_op == WOP_SET && !gate_miss) |=> ((level & $past(wdata)) == $past(wdata)));

  // R4
  clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_op == WOP_CLR && !gate_miss) |=> ((level & $past(wdata)) == '0));

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_miss |=> $stable(level));

  // R6
  edge_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_op == WOP_EDGE) |=> ($stable(level) && $stable(dir) && $stable(aux)));

  // R9
  bad_wr_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_op == WOP_BAD) |=> ($stable(level) && $stable(dir) && $stable(aux)));

endmodule

// File: rtl/gpio_sc_rdport.sv
module gpio_sc_rdport
  import gpio_sc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd,
  input  rd_kind_t rd_kind,
  input  word_t    level,
  input  word_t    dir,
  input  word_t    aux,
  output word_t    rdata
);

  word_t sel_word;

  always_comb begin
    case (rd_kind)
      RK_LEVEL: sel_word = level;
      RK_DIR:   sel_word = dir;
      RK_AUX:   sel_word = aux;
      default:  sel_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel_word;
  end

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  // R9
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rd_kind == RK_BAD) |=> (rdata == '0));

endmodule

// File: rtl/gpio_sc_top.sv
module gpio_sc_top
  import gpio_sc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe,
  output logic              access_err
);

  wr_op_t   wr_op;
  rd_kind_t rd_kind;
  word_t    level_w, dir_w, aux_w;
  logic     gate_miss;
  logic     wr_err, rd_err;

  gpio_sc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .wr_op   (wr_op),
    .rd_kind (rd_kind)
  );

  gpio_sc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .wr_op     (wr_op),
    .wdata     (bus_wdata),
    .level     (level_w),
    .dir       (dir_w),
    .aux       (aux_w),
    .gate_miss (gate_miss)
  );

  gpio_sc_rdport u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (bus_rd),
    .rd_kind (rd_kind),
    .level   (level_w),
    .dir     (dir_w),
    .aux     (aux_w),
    .rdata   (bus_rdata)
  );

  assign wr_err     = (bus_wr && wr_op == WOP_BAD) || gate_miss;
  assign rd_err     = bus_rd && rd_kind == RK_BAD;
  assign access_err = wr_err || rd_err;
  assign pad_out    = level_w;
  assign pad_oe     = dir_w;

  // R10
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> (bus_wr || bus_rd));

  // R5
  miss_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_miss |-> access_err);

endmodule

// File: tb/tb_gpio_sc_top.sv
module tb_gpio_sc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        access_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_lvl = '0, m_dir = '0, m_aux = '0;

  always #5 clk = ~clk;

  gpio_sc_top #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .access_err(access_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit wr_ok(input logic [7:0] a);
    return a == 8'h04 || a == 8'h08 || a == 8'h0C || a == 8'h10 ||
           a == 8'h14 || a == 8'h18 || a == 8'h20;
  endfunction

  function automatic bit rd_ok(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h20;
  endfunction

  // One access: drive at negedge, check strobe mid-cycle, release at next negedge.
  task automatic access(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] exp_rd;
    bit          exp_err;
    bit          pass;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    exp_err = 1'b0;
    if (w && !wr_ok(a)) exp_err = 1'b1;
    if (w && (a == 8'h08 || a == 8'h0C) && ((d & m_dir) == 32'h0)) exp_err = 1'b1;
    if (r && !rd_ok(a)) exp_err = 1'b1;
    exp_rd = (a == 8'h00) ? m_lvl : (a == 8'h04) ? m_dir : (a == 8'h20) ? m_aux : 32'h0;
    #1;
    check(w && (a == 8'h08 || a == 8'h0C) ? "R5 strobe" : "R9/R10 strobe",
          {31'b0, access_err}, {31'b0, exp_err});
    if (w) begin
      pass = (d & m_dir) != 32'h0;
      case (a)
        8'h04: m_dir = d;
        8'h08: if (pass) m_lvl = m_lvl | d;
        8'h0C: if (pass) m_lvl = m_lvl & ~d;
        8'h20: m_aux = d;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R3 pad_out", pad_out, m_lvl);
    check("R2 pad_oe", pad_oe, m_dir);
    if (r) check(rd_ok(a) ? "R1 rdata" : "R9 rdata", bus_rdata, exp_rd);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 pad_out", pad_out, 32'h0);
    check("R8 pad_oe", pad_oe, 32'h0);
    check("R8 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    access(0, 1, 8'h00, 0);
    access(0, 1, 8'h04, 0);
    access(0, 1, 8'h20, 0);  // R8 spare word reset

    access(1, 0, 8'h04, 32'h0000_FFFF);           // R2
    access(1, 0, 8'h08, 32'h000F_0000);           // R5 no overlap
    access(1, 0, 8'h08, 32'h00F0_00F0);           // R3 input bits also set
    access(0, 1, 8'h00, 0);                       // R1
    access(1, 0, 8'h0C, 32'h0F00_0000);           // R5 clear miss
    access(1, 0, 8'h0C, 32'h0030_0010);           // R4
    access(0, 1, 8'h00, 0);
    access(1, 0, 8'h10, 32'hFFFF_FFFF);           // R6
    access(1, 0, 8'h14, 32'hFFFF_FFFF);           // R6
    access(1, 0, 8'h18, 32'hFFFF_FFFF);           // R6
    access(1, 0, 8'h20, 32'hCAFE_F00D);           // R7
    access(0, 1, 8'h20, 0);
    access(1, 1, 8'h20, 32'h1234_5678);           // R1 old value returned
    access(0, 1, 8'h20, 0);                       // R7
    access(1, 1, 8'h00, 32'h0000_0001);           // R10 bad write + good read
    access(1, 1, 8'h10, 32'h0000_0001);           // R10 good write + bad read
    access(0, 0, 8'h00, 0);                       // R10 idle: no strobe
    @(negedge clk);
    check("R1 rdata hold", bus_rdata, 32'h0);

    // R9 sweep of the whole address space; model tracks every write.
    for (int a = 0; a < 256; a++) begin
      logic [31:0] v;
      v = (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      access(1, 0, 8'(a), v);
      access(0, 1, 8'(a), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule